// File: doc/BRIEF.md
# Dual-Channel ADC Ramp Pattern Checker

This block judges the integrity of an ADC capture path while the converter emits a counting test pattern. It watches the in-phase and quadrature sample streams with two independent lanes. A lane stays in a seek state until it sees a sample equal to zero, locks on that sample, and from then on compares every qualified sample against a locally generated ramp that advances by one per sample and wraps at the sample width. Each mismatch bumps a saturating error counter for that lane.

During a test one channel carries the ramp and the other is held at all ones, so only the channel under test can ever lock. Because lock flags and error counts are kept per channel, a swapped I/Q wiring shows up as the wrong lane locking. Software re-arms both lanes by taking the enable low and back high, runs the pattern, and then reads the lock flags and counts. A lane that never locked reads back as unlocked, which is distinct from a lane that locked and counted zero errors.

Top module: `ramp_chk_pair`

## Requirements
- R1: While reset is high, and on the edge after it, both lock flags are low and both error counts are zero.
- R2: An unlocked lane ignores every non-zero sample: its lock flag stays low and its count stays zero.
- R3: A valid sample equal to zero on an unlocked, enabled lane raises its lock flag on the next clock edge; the next expected sample is 1, and each following valid sample advances the expectation by one, so a matching ramp leaves the count unchanged.
- R4: Each valid sample on a locked lane that differs from the expected value raises that lane's count by one on the next edge, and the expectation still advances by one.
- R5: The expected value wraps from all ones (2^SMP_W-1) to zero.
- R6: A cycle with the valid input low changes neither lock flag, expected value nor count.
- R7: The error count saturates at 2^CNT_W-1 and never wraps.
- R8: With the enable low, both lanes clear lock, expectation and count on the next edge and ignore all samples; this clear wins over a sample in the same cycle.
- R9: The I and Q lanes are independent: a lane held at all ones never locks while the other locks and counts, so a channel swap is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Checker enable; low clears both lanes |
| smp_vld | input | 1 | Qualifies both sample inputs this cycle |
| smp_i | input | SMP_W | In-phase sample |
| smp_q | input | SMP_W | Quadrature sample |
| lock_i | output | 1 | In-phase lane has locked to the ramp |
| errs_i | output | CNT_W | In-phase mismatch count (saturating) |
| lock_q | output | 1 | Quadrature lane has locked to the ramp |
| errs_q | output | CNT_W | Quadrature mismatch count (saturating) |

## Verification
The clear from a falling enable and a mismatch count on a locked lane can both be due on the same edge. The bench provokes this by dropping the enable in the very cycle a wrong sample is presented to a locked lane whose count is already saturated, and judges that the count reads zero and the lock is gone afterwards. It likewise presents a zero sample with the enable low, expecting no lock, and then re-arms with the ramp on the other channel to confirm the lanes stay separate.

// File: rtl/ramp_chk_pkg.sv
`timescale 1ns/1ps
package ramp_chk_pkg;
  // Lane tracking state
  typedef enum logic {
    ST_SEEK  = 1'b0,
    ST_TRACK = 1'b1
  } lane_st_e;

  localparam int NUM_LANES = 2;
  localparam int LANE_I    = 0;
  localparam int LANE_Q    = 1;
endpackage

// File: rtl/ramp_err_counter.sv
`timescale 1ns/1ps
module ramp_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (bump && (count != TOP)) begin
      count <= count + 1'b1;
    end
  end

  // R7: a full counter holds its value
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (count == TOP && !clr) |=> (count == TOP));
endmodule

// File: rtl/ramp_chk_lane.sv
`timescale 1ns/1ps
module ramp_chk_lane
  import ramp_chk_pkg::*;
#(
  parameter int SMP_W = 14,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             vld,
  input  logic [SMP_W-1:0] smp,
  output logic             locked,
  output logic [CNT_W-1:0] errs
);
  localparam logic [SMP_W-1:0] ONE  = SMP_W'(1);
  localparam logic [CNT_W-1:0] CTOP = '1;

  lane_st_e         st;
  logic [SMP_W-1:0] expect_q;
  logic             take;
  logic             miss;

  assign take = arm && vld;
  assign miss = take && (st == ST_TRACK) && (smp != expect_q);

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      st       <= ST_SEEK;
      expect_q <= '0;
    end else if (vld) begin
      case (st)
        ST_SEEK: begin
          if (smp == '0) begin
            st       <= ST_TRACK;
            expect_q <= ONE;
          end
        end
        default: expect_q <= expect_q + ONE;
      endcase
    end
  end

  assign locked = (st == ST_TRACK);

  ramp_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (!arm),
    .bump (miss),
    .count(errs)
  );

  // R1: reset leaves the lane empty
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!locked && errs == '0));
  // R2: non-zero samples never lock a seeking lane
  a_r2_no_false_lock: assert property (@(posedge clk) disable iff (rst)
    (!locked && arm && smp != '0) |=> (!locked && errs == '0));
  // R3: zero sample locks
  a_r3_lock_on_zero: assert property (@(posedge clk) disable iff (rst)
    (!locked && take && smp == '0) |=> (locked && expect_q == ONE));
  // R3: matching sample keeps count
  a_r3_match_quiet: assert property (@(posedge clk) disable iff (rst)
    (locked && take && smp == expect_q) |=> $stable(errs));
  // R4: mismatch adds one
  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (locked && take && smp != expect_q && errs != CTOP) |=> (errs == $past(errs) + 1'b1));
  // R6: idle cycles change nothing
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (arm && !vld) |=> ($stable(errs) && $stable(locked) && $stable(expect_q)));
  // R8: disable clears everything
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (!arm) |=> (!locked && errs == '0 && expect_q == '0));
endmodule

// File: rtl/ramp_chk_pair.sv
`timescale 1ns/1ps
module ramp_chk_pair
  import ramp_chk_pkg::*;
#(
  parameter int SMP_W = 14,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [SMP_W-1:0] smp_q,
  output logic             lock_i,
  output logic [CNT_W-1:0] errs_i,
  output logic             lock_q,
  output logic [CNT_W-1:0] errs_q
);
  logic [SMP_W-1:0] smp_arr  [NUM_LANES];
  logic             lock_arr [NUM_LANES];
  logic [CNT_W-1:0] errs_arr [NUM_LANES];

  assign smp_arr[LANE_I] = smp_i;
  assign smp_arr[LANE_Q] = smp_q;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    ramp_chk_lane #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .arm   (arm),
      .vld   (smp_vld),
      .smp   (smp_arr[g]),
      .locked(lock_arr[g]),
      .errs  (errs_arr[g])
    );
  end

  assign lock_i = lock_arr[LANE_I];
  assign errs_i = errs_arr[LANE_I];
  assign lock_q = lock_arr[LANE_Q];
  assign errs_q = errs_arr[LANE_Q];

  // R9: a lane fed all ones never locks
  a_r9_ones_never_lock_i: assert property (@(posedge clk) disable iff (rst)
    (!lock_i && smp_i == '1) |=> !lock_i);
  a_r9_ones_never_lock_q: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && smp_q == '1) |=> !lock_q);
endmodule

// File: tb/ramp_chk_pair_test.sv
`timescale 1ns/1ps
module ramp_chk_pair_test;
  localparam int SW = 6;
  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [SW-1:0] ONES = '1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          arm = 1'b0;
  logic          vld = 1'b0;
  logic [SW-1:0] smp_i = '0;
  logic [SW-1:0] smp_q = '0;
  logic          lock_i, lock_q;
  logic [CW-1:0] errs_i, errs_q;

  ramp_chk_pair #(.SMP_W(SW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .arm(arm), .smp_vld(vld),
    .smp_i(smp_i), .smp_q(smp_q),
    .lock_i(lock_i), .errs_i(errs_i),
    .lock_q(lock_q), .errs_q(errs_q)
  );

  typedef struct {
    logic          lk_i;
    logic [CW-1:0] er_i;
    logic          lk_q;
    logic [CW-1:0] er_q;
    string         tag;
  } exp_t;

  exp_t sbq[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state from the requirements
  logic          m_lk [2];
  logic [SW-1:0] m_ex [2];
  logic [CW-1:0] m_er [2];

  task automatic model_step(input int ln, input logic a, input logic v, input logic [SW-1:0] s);
    if (!a) begin
      m_lk[ln] = 1'b0; m_ex[ln] = '0; m_er[ln] = '0;
    end else if (v) begin
      if (!m_lk[ln]) begin
        if (s == '0) begin m_lk[ln] = 1'b1; m_ex[ln] = SW'(1); end
      end else begin
        if (s != m_ex[ln] && m_er[ln] != CMAX) m_er[ln] = m_er[ln] + 1'b1;
        m_ex[ln] = m_ex[ln] + SW'(1);
      end
    end
  endtask

  task automatic drive(input logic a, input logic v, input logic [SW-1:0] si,
                       input logic [SW-1:0] sq, input string tag);
    exp_t e;
    @(negedge clk);
    arm = a; vld = v; smp_i = si; smp_q = sq;
    model_step(0, a, v, si);
    model_step(1, a, v, sq);
    e.lk_i = m_lk[0]; e.er_i = m_er[0];
    e.lk_q = m_lk[1]; e.er_q = m_er[1];
    e.tag  = tag;
    sbq.push_back(e);
  endtask

  // monitor: compare one item per edge, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (lock_i !== e.lk_i || errs_i !== e.er_i || lock_q !== e.lk_q || errs_q !== e.er_q) begin
          fails++;
          $display("FAIL %s: actual I=%0b/%0d Q=%0b/%0d expected I=%0b/%0d Q=%0b/%0d",
                   e.tag, lock_i, errs_i, lock_q, errs_q, e.lk_i, e.er_i, e.lk_q, e.er_q);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (R1..all): actual still running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin m_lk[k] = 0; m_ex[k] = '0; m_er[k] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state, sampled after reset edges
    checks++;
    if (lock_i !== 1'b0 || errs_i !== '0 || lock_q !== 1'b0 || errs_q !== '0) begin
      fails++;
      $display("FAIL R1: actual I=%0b/%0d Q=%0b/%0d expected all zero", lock_i, errs_i, lock_q, errs_q);
    end
    rst = 1'b0;
    drive(1'b1, 1'b1, 6'd5, ONES, "R1");
    // R2: non-zero samples do not lock
    drive(1'b1, 1'b1, 6'd7,  ONES, "R2");
    drive(1'b1, 1'b1, 6'd33, ONES, "R2");
    // R6: zero with valid low is not taken
    drive(1'b1, 1'b0, 6'd0,  ONES, "R6");
    // R3: lock on zero
    drive(1'b1, 1'b1, 6'd0,  ONES, "R3");
    for (int n = 0; n < 10; n++) begin
      drive(1'b1, 1'b1, m_ex[0], ONES, "R3");
      if (n % 3 == 0) drive(1'b1, 1'b0, 6'd42, 6'd0, "R6");
    end
    // R4: injected mismatches, ramp continues
    for (int n = 0; n < 3; n++) begin
      drive(1'b1, 1'b1, m_ex[0] ^ 6'd4, ONES, "R4");
      drive(1'b1, 1'b1, m_ex[0], ONES, "R4");
    end
    // R5: run the ramp through the wrap point
    for (int n = 0; n < 70; n++) drive(1'b1, 1'b1, m_ex[0], ONES, "R5");
    // R7: saturate the count
    for (int n = 0; n < 20; n++) drive(1'b1, 1'b1, m_ex[0] + 6'd9, ONES, "R7");
    drive(1'b1, 1'b1, m_ex[0] + 6'd9, ONES, "R7");
    // R8: disable collides with a mismatch on a saturated lane
    drive(1'b0, 1'b1, m_ex[0] + 6'd1, ONES, "R8");
    drive(1'b0, 1'b1, 6'd0, 6'd0, "R8");
    drive(1'b0, 1'b1, 6'd1, 6'd1, "R8");
    // R9: swap, ramp on Q while I held at ones
    drive(1'b1, 1'b1, ONES, 6'd0, "R9");
    for (int n = 0; n < 8; n++) drive(1'b1, 1'b1, ONES, m_ex[1], "R9");
    drive(1'b1, 1'b1, ONES, m_ex[1] ^ 6'd1, "R9");
    drive(1'b1, 1'b1, ONES, m_ex[1], "R9");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule